// File: doc/BRIEF.md
# CAN Frame Serializer with Bit Stuffing

This block turns one CAN data or remote frame into a serial bit stream. A host presents the frame fields in parallel: a format flag selecting the 11-bit or 29-bit identifier layout, the remote-request flag, the identifier, the 4-bit length code, up to eight payload bytes and a CRC that has already been computed. A start pulse is accepted only while the block is idle and the bus is quiet. On acceptance the block latches the whole frame. After that the input fields may change freely.

The block then drives one bit per bit-timing strobe. It sends start-of-frame, the header fields, the payload and the CRC, and inserts complementary stuff bits as the frame goes out. Thirteen unstuffed recessive bits close the frame, after which a one-cycle done pulse is raised. At each sample-point strobe inside the arbitration field the block compares the bus level with what it sent. If it sent recessive and sees dominant, it stops driving, returns to idle and reports the loss.

Top module: `can_frame_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `tx_bit` is 1 (recessive) and `busy`, `arb_lost` and `done` are 0.
- R2: A `start` pulse is accepted only when the block is idle and `bus_quiet` is 1. Acceptance raises `busy` on the next cycle. A start pulse seen while `bus_quiet` is 0 leaves `busy` at 0 and `tx_bit` at 1.
- R3: With `ext_fmt`=0 the transmitted bits before any stuffing are as follows. First a 0 (frame start), then `ident[10:0]` MSB first. Then `rtr`, then two 0 bits, then `dlc[3:0]` MSB first. Then the payload bytes, byte 0 in `payload[63:56]` first and each byte MSB first. Then `crc[14:0]` MSB first.
- R4: With `ext_fmt`=1 the unstuffed bits are as follows. First a 0, then `ident[28:18]`, then two 1 bits. Then `ident[17:0]`, then `rtr`, then two 0 bits. Then `dlc[3:0]`, then the payload and CRC, ordered as in R3.
- R5: With `rtr`=1 no payload bytes are sent, whatever the length code. The length code itself is still sent unchanged.
- R6: A length code above 8 sends eight payload bytes, while the 4-bit code field carries the value given.
- R7: From frame start through the last CRC bit, the block inserts one bit of opposite value after every five consecutive equal bits; stuff bits count toward the next run. This includes a stuff bit directly after the last CRC bit when the run requires one.
- R8: After the stuffed part the block sends 13 recessive bits without stuffing. On the next strobe `done` is high for exactly one cycle while `busy` falls. `tx_bit` changes only at a bit-timing strobe, except on arbitration loss.
- R9: The arbitration field is unstuffed bit positions 1 to 12 (standard) or 1 to 32 (extended). If a recessive bit in that field is sampled dominant on `bus_rx` at a sample-point strobe, then on the next cycle `arb_lost` is 1, `busy` is 0 and `tx_bit` is 1, and no `done` pulse follows. `arb_lost` holds until the next accepted start.
- R10: A dominant sample has no effect when the block is sending a dominant bit, when it is sending a stuff bit, or when the bit lies outside the arbitration field.
- R11: A start pulse while `busy` is high is ignored, and the frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | Bit-timing strobe: start of a new bit |
| smp_stb | input | 1 | Sample-point strobe |
| bus_rx | input | 1 | Bus level at the sample point (0 = dominant) |
| bus_quiet | input | 1 | High when no error or interframe activity is under way |
| start | input | 1 | Request to send the presented frame |
| ext_fmt | input | 1 | 1 = 29-bit identifier layout |
| rtr | input | 1 | Remote request flag |
| ident | input | 29 | Identifier (standard uses bits 10:0) |
| dlc | input | 4 | Length code |
| payload | input | 64 | Payload, byte 0 in bits 63:56 |
| crc | input | 15 | Precomputed CRC |
| tx_bit | output | 1 | Serial bit to the bus driver |
| busy | output | 1 | Frame in progress |
| arb_lost | output | 1 | Arbitration lost in the last frame |
| done | output | 1 | One-cycle pulse at frame completion |

## Verification
A corrupted run counter or stuff decision inside this block shows at `tx_bit` within six strobes, either as a sixth equal bit or as a stray complement. After that, every later bit position of the frame is shifted. A wrong remaining-bit count or header length appears as a frame whose length or trailer start is off, and this shows in the done-pulse strobe. A wrong arbitration window appears as a missed or false `arb_lost` one cycle after the sample strobe that probes a window edge: bit 12, bit 13, or a dominant or stuff position.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

    localparam int CAN_MAX_BYTES = 8;
    localparam int ID_W          = 29;
    localparam int DLC_W         = 4;
    localparam int CRC_W         = 15;
    localparam int HDR_STD       = 19;
    localparam int HDR_EXT       = 39;
    localparam int ARB_STD       = 12;
    localparam int ARB_EXT       = 32;
    localparam int TRAIL_BITS    = 13;
    localparam int STUFF_RUN     = 5;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_BODY  = 2'd1,
        TX_TRAIL = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic             ext;
        logic             rtr;
        logic [ID_W-1:0]  id;
        logic [DLC_W-1:0] dlc;
    } frame_hdr_t;

    // Number of payload bytes actually sent
    function automatic int unsigned sent_bytes(input frame_hdr_t h, input int unsigned max_b);
        int unsigned n;
        n = h.rtr ? 0 : int'(h.dlc);
        if (n > max_b) n = max_b;
        return n;
    endfunction

    // Header bits, left aligned in HDR_EXT bits, frame start included
    function automatic logic [HDR_EXT-1:0] header_bits(input frame_hdr_t h);
        logic [HDR_EXT-1:0] v;
        if (h.ext)
            v = {1'b0, h.id[28:18], 1'b1, 1'b1, h.id[17:0], h.rtr, 2'b00, h.dlc};
        else
            v = {1'b0, h.id[10:0], h.rtr, 1'b0, 1'b0, h.dlc, {(HDR_EXT-HDR_STD){1'b0}}};
        return v;
    endfunction

endpackage

// File: rtl/can_frame_build.sv
module can_frame_build
    import can_tx_pkg::*;
#(
    parameter int MAX_BYTES = CAN_MAX_BYTES,
    localparam int PAY_W    = 8 * MAX_BYTES,
    localparam int BODY_W   = PAY_W + CRC_W,
    localparam int FRAME_W  = HDR_EXT + BODY_W,
    localparam int LEN_W    = $clog2(FRAME_W + 1)
) (
    input  frame_hdr_t         hdr,
    input  logic [PAY_W-1:0]   payload,
    input  logic [CRC_W-1:0]   crc,
    output logic [FRAME_W-1:0] frame_vec,
    output logic [LEN_W-1:0]   frame_len,
    output logic [5:0]         arb_len
);
    logic [LEN_W-1:0]   data_bits;
    logic [LEN_W-1:0]   hdr_len;
    logic [PAY_W-1:0]   data_keep;
    logic [BODY_W-1:0]  body;
    logic [HDR_EXT-1:0] hdr_vec;

    always_comb begin
        data_bits = LEN_W'(8 * sent_bytes(hdr, MAX_BYTES));
        hdr_len   = hdr.ext ? LEN_W'(HDR_EXT) : LEN_W'(HDR_STD);
        arb_len   = hdr.ext ? 6'(ARB_EXT) : 6'(ARB_STD);
        hdr_vec   = header_bits(hdr);
        data_keep = payload & ~({PAY_W{1'b1}} >> data_bits);
        body      = {data_keep, {CRC_W{1'b0}}} | ({crc, {PAY_W{1'b0}}} >> data_bits);
        frame_vec = {hdr_vec, {BODY_W{1'b0}}} | ({body, {HDR_EXT{1'b0}}} >> hdr_len);
        frame_len = hdr_len + data_bits + LEN_W'(CRC_W);
    end

endmodule

// File: rtl/can_arb_watch.sv
module can_arb_watch
    import can_tx_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             smp_stb,
    input  logic             bus_rx,
    input  logic             tx_bit,
    input  logic             in_body,
    input  logic             cur_data,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [5:0]       arb_len,
    output logic             lose
);
    logic in_window;

    always_comb begin
        in_window = cur_data && (cur_idx != '0) && (cur_idx <= IDX_W'(arb_len));
        lose      = smp_stb && in_body && in_window && tx_bit && !bus_rx;
    end

endmodule

// File: rtl/can_tx_seq.sv
module can_tx_seq
    import can_tx_pkg::*;
#(
    parameter int FRAME_W = 118,
    localparam int LEN_W  = $clog2(FRAME_W + 1),
    localparam int TRL_W  = $clog2(TRAIL_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_stb,
    input  logic               accept,
    input  logic               lose,
    input  logic [FRAME_W-1:0] frame_vec,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic [5:0]         arb_len_in,
    output logic               tx_bit,
    output logic               busy,
    output logic               done,
    output logic               arb_lost,
    output logic               in_body,
    output logic               cur_data,
    output logic [LEN_W-1:0]   cur_idx,
    output logic [5:0]         arb_len
);
    tx_state_e          state_q;
    logic [FRAME_W-1:0] shift_q;
    logic [LEN_W-1:0]   left_q;
    logic [LEN_W-1:0]   next_idx_q;
    logic [2:0]         run_q;
    logic               last_q;
    logic [TRL_W-1:0]   trail_q;
    logic               head_bit;
    logic               stuff_due;

    assign head_bit  = shift_q[FRAME_W-1];
    assign stuff_due = (run_q == 3'(STUFF_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= TX_IDLE;
            shift_q    <= '0;
            left_q     <= '0;
            next_idx_q <= '0;
            run_q      <= '0;
            last_q     <= 1'b1;
            trail_q    <= '0;
            tx_bit     <= 1'b1;
            done       <= 1'b0;
            arb_lost   <= 1'b0;
            cur_data   <= 1'b0;
            cur_idx    <= '0;
            arb_len    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                TX_IDLE: begin
                    if (accept) begin
                        state_q    <= TX_BODY;
                        shift_q    <= frame_vec;
                        left_q     <= frame_len;
                        arb_len    <= arb_len_in;
                        next_idx_q <= '0;
                        run_q      <= '0;
                        last_q     <= 1'b1;
                        cur_data   <= 1'b0;
                        arb_lost   <= 1'b0;
                    end
                end
                TX_BODY: begin
                    if (lose) begin
                        state_q  <= TX_IDLE;
                        tx_bit   <= 1'b1;
                        arb_lost <= 1'b1;
                        cur_data <= 1'b0;
                    end else if (bit_stb) begin
                        if (stuff_due) begin
                            tx_bit   <= ~last_q;
                            last_q   <= ~last_q;
                            run_q    <= 3'd1;
                            cur_data <= 1'b0;
                        end else if (left_q != '0) begin
                            tx_bit     <= head_bit;
                            last_q     <= head_bit;
                            run_q      <= (head_bit == last_q) ? run_q + 3'd1 : 3'd1;
                            shift_q    <= shift_q << 1;
                            left_q     <= left_q - 1'b1;
                            cur_idx    <= next_idx_q;
                            next_idx_q <= next_idx_q + 1'b1;
                            cur_data   <= 1'b1;
                        end else begin
                            state_q  <= TX_TRAIL;
                            tx_bit   <= 1'b1;
                            trail_q  <= TRL_W'(1);
                            cur_data <= 1'b0;
                        end
                    end
                end
                TX_TRAIL: begin
                    if (bit_stb) begin
                        if (trail_q == TRL_W'(TRAIL_BITS)) begin
                            state_q <= TX_IDLE;
                            done    <= 1'b1;
                        end else begin
                            trail_q <= trail_q + 1'b1;
                        end
                        tx_bit <= 1'b1;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != TX_IDLE);
    assign in_body = (state_q == TX_BODY);

endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
    import can_tx_pkg::*;
#(
    parameter int MAX_BYTES = CAN_MAX_BYTES,
    localparam int PAY_W    = 8 * MAX_BYTES,
    localparam int FRAME_W  = HDR_EXT + PAY_W + CRC_W,
    localparam int LEN_W    = $clog2(FRAME_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             smp_stb,
    input  logic             bus_rx,
    input  logic             bus_quiet,
    input  logic             start,
    input  logic             ext_fmt,
    input  logic             rtr,
    input  logic [ID_W-1:0]  ident,
    input  logic [DLC_W-1:0] dlc,
    input  logic [PAY_W-1:0] payload,
    input  logic [CRC_W-1:0] crc,
    output logic             tx_bit,
    output logic             busy,
    output logic             arb_lost,
    output logic             done
);
    frame_hdr_t         hdr;
    logic [FRAME_W-1:0] frame_vec;
    logic [LEN_W-1:0]   frame_len;
    logic [5:0]         arb_len_new;
    logic [5:0]         arb_len_q;
    logic               accept;
    logic               lose;
    logic               in_body;
    logic               cur_data;
    logic [LEN_W-1:0]   cur_idx;

    assign hdr    = '{ext: ext_fmt, rtr: rtr, id: ident, dlc: dlc};
    assign accept = start && bus_quiet && !busy;

    can_frame_build #(.MAX_BYTES(MAX_BYTES)) build_i (
        .hdr       (hdr),
        .payload   (payload),
        .crc       (crc),
        .frame_vec (frame_vec),
        .frame_len (frame_len),
        .arb_len   (arb_len_new)
    );

    can_tx_seq #(.FRAME_W(FRAME_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .accept     (accept),
        .lose       (lose),
        .frame_vec  (frame_vec),
        .frame_len  (frame_len),
        .arb_len_in (arb_len_new),
        .tx_bit     (tx_bit),
        .busy       (busy),
        .done       (done),
        .arb_lost   (arb_lost),
        .in_body    (in_body),
        .cur_data   (cur_data),
        .cur_idx    (cur_idx),
        .arb_len    (arb_len_q)
    );

    can_arb_watch #(.IDX_W(LEN_W)) watch_i (
        .smp_stb  (smp_stb),
        .bus_rx   (bus_rx),
        .tx_bit   (tx_bit),
        .in_body  (in_body),
        .cur_data (cur_data),
        .cur_idx  (cur_idx),
        .arb_len  (arb_len_q),
        .lose     (lose)
    );

endmodule

// File: rtl/can_frame_tx_chk.sv
module can_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic bit_stb,
    input logic smp_stb,
    input logic bus_rx,
    input logic bus_quiet,
    input logic start,
    input logic tx_bit,
    input logic busy,
    input logic arb_lost,
    input logic done
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (tx_bit && !busy && !arb_lost && !done));

    // R2
    quiet_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !bus_quiet) |=> !busy);

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_stb && !smp_stb) |=> $stable(tx_bit));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && tx_bit));

    // R9
    lost_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> (!busy && tx_bit && !done));

    // R10
    lost_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> ($past(smp_stb) && !$past(bus_rx) && $past(tx_bit)));

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !bit_stb && !smp_stb) |=> busy);

endmodule

bind can_frame_tx can_frame_tx_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .smp_stb   (smp_stb),
    .bus_rx    (bus_rx),
    .bus_quiet (bus_quiet),
    .start     (start),
    .tx_bit    (tx_bit),
    .busy      (busy),
    .arb_lost  (arb_lost),
    .done      (done)
);

// File: tb/can_frame_tx_tb_top.sv
`timescale 1ns/1ps
module can_frame_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_stb = 1'b0;
    logic        smp_stb = 1'b0;
    logic        bus_rx = 1'b1;
    logic        bus_quiet = 1'b1;
    logic        start = 1'b0;
    logic        ext_fmt = 1'b0;
    logic        rtr = 1'b0;
    logic [28:0] ident = '0;
    logic [3:0]  dlc = '0;
    logic [63:0] payload = '0;
    logic [14:0] crc = '0;
    logic        tx_bit;
    logic        busy;
    logic        arb_lost;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit raw_b [0:159];
    int raw_n;
    bit exp_b [0:319];
    int exp_idx [0:319];
    int exp_n;

    always #10 clk = ~clk;

    can_frame_tx dut_i (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .smp_stb(smp_stb),
        .bus_rx(bus_rx), .bus_quiet(bus_quiet), .start(start),
        .ext_fmt(ext_fmt), .rtr(rtr), .ident(ident), .dlc(dlc),
        .payload(payload), .crc(crc), .tx_bit(tx_bit), .busy(busy),
        .arb_lost(arb_lost), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic push_raw(input bit b);
        raw_b[raw_n] = b;
        raw_n++;
    endtask

    task automatic push_exp(input bit b, input int idx);
        exp_b[exp_n] = b;
        exp_idx[exp_n] = idx;
        exp_n++;
    endtask

    // Expected bit stream from R3..R8
    task automatic build_model(input bit e, input bit r, input logic [28:0] id,
                               input logic [3:0] l, input logic [63:0] p,
                               input logic [14:0] c);
        int nb;
        int run;
        bit last;
        raw_n = 0;
        exp_n = 0;
        push_raw(1'b0);
        if (e) begin
            for (int i = 28; i >= 18; i--) push_raw(id[i]);
            push_raw(1'b1);
            push_raw(1'b1);
            for (int i = 17; i >= 0; i--) push_raw(id[i]);
        end else begin
            for (int i = 10; i >= 0; i--) push_raw(id[i]);
        end
        push_raw(r);
        push_raw(1'b0);
        push_raw(1'b0);
        for (int i = 3; i >= 0; i--) push_raw(l[i]);
        nb = r ? 0 : ((int'(l) > 8) ? 8 : int'(l));
        for (int k = 0; k < nb; k++)
            for (int b = 7; b >= 0; b--) push_raw(p[56 - 8*k + b]);
        for (int i = 14; i >= 0; i--) push_raw(c[i]);
        run = 0;
        last = 1'b1;
        for (int i = 0; i < raw_n; i++) begin
            if (run == 5) begin
                push_exp(~last, -1);
                last = ~last;
                run = 1;
            end
            push_exp(raw_b[i], i);
            run = (raw_b[i] == last) ? run + 1 : 1;
            last = raw_b[i];
        end
        if (run == 5) push_exp(~last, -1);
        for (int i = 0; i < 13; i++) push_exp(1'b1, -2);
    endtask

    // dom_raw: unstuffed position where the bus is forced dominant (-1: none)
    task automatic run_frame(input string req, input bit e, input bit r,
                             input logic [28:0] id, input logic [3:0] l,
                             input logic [63:0] p, input logic [14:0] c,
                             input int dom_raw, input bit poke);
        int mism;
        int first_bad;
        int first_act;
        int first_exp;
        int arb;
        bit lose_exp;
        build_model(e, r, id, l, p, c);
        arb = e ? 32 : 12;
        @(negedge clk);
        ext_fmt = e; rtr = r; ident = id; dlc = l; payload = p; crc = c;
        bus_quiet = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", {req, " busy after start"}, busy, 1);
        chk(arb_lost == 1'b0 && tx_bit == 1'b1, "R9", {req, " clean state after start"}, arb_lost, 0);
        // scramble inputs: the latched frame must not change
        ext_fmt = ~e; rtr = ~r; ident = ~id; dlc = ~l; payload = ~p; crc = ~c;
        mism = 0; first_bad = -1; first_act = 0; first_exp = 0;
        for (int q = 0; q < exp_n; q++) begin
            bit_stb = 1'b1;
            if (poke && q == 3) start = 1'b1;
            @(negedge clk);
            bit_stb = 1'b0;
            start = 1'b0;
            if (tx_bit !== exp_b[q]) begin
                if (mism == 0) begin
                    first_bad = q; first_act = tx_bit; first_exp = exp_b[q];
                end
                mism++;
            end
            lose_exp = (exp_idx[q] == dom_raw) && (dom_raw >= 0) && exp_b[q] &&
                       (exp_idx[q] >= 1) && (exp_idx[q] <= arb);
            bus_rx = (exp_idx[q] == dom_raw && dom_raw >= 0) ? 1'b0 : exp_b[q];
            smp_stb = 1'b1;
            @(negedge clk);
            smp_stb = 1'b0;
            bus_rx = 1'b1;
            if (lose_exp) begin
                chk(mism == 0, req, "bits before loss", first_act, first_exp);
                chk(arb_lost == 1'b1, "R9", {req, " arb_lost"}, arb_lost, 1);
                chk(busy == 1'b0 && tx_bit == 1'b1, "R9", {req, " idle recessive"}, busy, 0);
                for (int k = 0; k < 20; k++) begin
                    bit_stb = 1'b1;
                    @(negedge clk);
                    bit_stb = 1'b0;
                    if (tx_bit !== 1'b1 || done !== 1'b0) mism++;
                end
                chk(mism == 0, "R9", {req, " recessive, no done after loss"}, mism, 0);
                chk(arb_lost == 1'b1, "R9", {req, " arb_lost holds"}, arb_lost, 1);
                return;
            end
        end
        chk(mism == 0, req, $sformatf("%s bit stream (first bad pos %0d)", req, first_bad),
            first_act, first_exp);
        chk(busy == 1'b1 && done == 1'b0, "R8", {req, " busy through trailer"}, busy, 1);
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        chk(done == 1'b1 && busy == 1'b0 && tx_bit == 1'b1, "R8", {req, " done pulse"}, done, 1);
        chk(arb_lost == 1'b0, "R10", {req, " no arb loss"}, arb_lost, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", {req, " done one cycle"}, done, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_bit == 1'b1 && busy == 1'b0 && arb_lost == 1'b0 && done == 1'b0,
            "R1", "reset state", {tx_bit, busy, arb_lost, done}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_bit == 1'b1 && busy == 1'b0, "R1", "after reset", busy, 0);
    endtask

    task automatic t_quiet_block();
        @(negedge clk);
        bus_quiet = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && tx_bit == 1'b1, "R2", "start ignored while bus not quiet", busy, 0);
        bus_quiet = 1'b1;
    endtask

    task automatic t_std();       // R3, R7
        run_frame("R3", 1'b0, 1'b0, 29'h123, 4'd2, 64'hA5F0_0000_0000_0000, 15'h1234, -1, 1'b0);
    endtask

    task automatic t_ext();       // R4
        run_frame("R4", 1'b1, 1'b0, 29'h0ABC_DEF1, 4'd8, 64'h0123_4567_89AB_CDEF, 15'h7001, -1, 1'b0);
    endtask

    task automatic t_rtr();       // R5
        run_frame("R5", 1'b0, 1'b1, 29'h5A5, 4'd4, 64'hFFFF_FFFF_0000_0000, 15'h2AAA, -1, 1'b0);
    endtask

    task automatic t_clamp();     // R6
        run_frame("R6", 1'b0, 1'b0, 29'h3C3, 4'd12, 64'h1122_3344_5566_7788, 15'h0F0F, -1, 1'b0);
    endtask

    task automatic t_stuff();     // R7: long runs, stuff bit after last CRC bit
        run_frame("R7", 1'b0, 1'b0, 29'h000, 4'd0, 64'h0, 15'h4A60, -1, 1'b0);
        run_frame("R7", 1'b1, 1'b0, 29'h1FFF_FFFF, 4'd1, 64'h0, 15'h7FFF, -1, 1'b0);
    endtask

    task automatic t_busy_start(); // R11
        run_frame("R11", 1'b0, 1'b0, 29'h2F1, 4'd1, 64'h3C00_0000_0000_0000, 15'h0555, -1, 1'b1);
    endtask

    task automatic t_arb_std();   // R9: loss on identifier bit
        run_frame("R9", 1'b0, 1'b0, 29'h7FF, 4'd0, 64'h0, 15'h0001, 2, 1'b0);
        // next frame must clear the flag
        run_frame("R9", 1'b0, 1'b0, 29'h111, 4'd0, 64'h0, 15'h0002, -1, 1'b0);
    endtask

    task automatic t_arb_edge();  // R9: loss on last arbitration bit (remote flag)
        run_frame("R9", 1'b0, 1'b1, 29'h000, 4'd0, 64'h0, 15'h0003, 12, 1'b0);
    endtask

    task automatic t_arb_ext();   // R9: loss in second identifier part
        run_frame("R9", 1'b1, 1'b0, 29'h1FFF_FFFF, 4'd0, 64'h0, 15'h0004, 25, 1'b0);
    endtask

    task automatic t_no_loss();   // R10: dominant on dominant bit, and outside field
        run_frame("R10", 1'b0, 1'b0, 29'h000, 4'd0, 64'h0, 15'h1111, 1, 1'b0);
        run_frame("R10", 1'b0, 1'b0, 29'h000, 4'd1, 64'hFF00_0000_0000_0000, 15'h2222, 19, 1'b0);
        run_frame("R10", 1'b0, 1'b1, 29'h000, 4'd0, 64'h0, 15'h3333, 13, 1'b0);
    endtask

    initial begin
        t_reset();
        t_quiet_block();
        t_std();
        t_ext();
        t_rtr();
        t_clamp();
        t_stuff();
        t_busy_start();
        t_arb_std();
        t_arb_edge();
        t_arb_ext();
        t_no_loss();
        repeat (5) @(negedge clk);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not complete", 0, 1);
        summary();
    end

endmodule